// File: doc/BRIEF.md
# Table-Driven Refresh Waveform Sequencer

This block plays a display-refresh drive waveform out of a small byte-wide lookup table. Software fills the table through a simple write port. A start pulse then makes the sequencer walk the table group by group. Each group holds four phases, and each phase has its own 2-bit drive-level code and a frame count. Each group also has a repeat count. The sequencer advances on an external frame tick and presents the level code of the phase now playing. A downstream driver reads that code as a common-electrode level (00 DC, 01 high, 10 low, 11 floating) or as a source-side level (00 ground, 01 high positive, 10 low negative, 11 extra-high positive). The sequencer itself treats the code as opaque.

An active-low busy flag tells the host that a waveform is playing. A mode input, latched at start, picks how many groups are played. The full table is used for three-color panels, and only a leading subset is used for two-color panels. Frame counts and repeat counts of zero let a table leave out phases or whole groups.

Top module: `wave_phase_seq`

## Requirements
- R1: After reset, busy_n is 1 and level_code is 00, and every table byte reads as zero.
- R2: A start pulse while busy_n is 1 drives busy_n to 0 on the next clock edge.
- R3: Group g occupies byte addresses 6g to 6g+5. Byte 6g is the level byte, bytes 6g+1 to 6g+4 are the frame counts of phases 0 to 3, and byte 6g+5 is the repeat count.
- R4: Within the level byte, phase 0 takes bits [7:6], phase 1 [5:4], phase 2 [3:2] and phase 3 [1:0]. While a phase plays, level_code equals its code.
- R5: A phase with frame count F (1 to 255) holds level_code for exactly F frame ticks.
- R6: A phase with frame count 0 is passed over without using any frame tick.
- R7: A repeat count of N plays the group's four phases N times in a row. A repeat count of 0 passes the group over.
- R8: With two_color_mode at 0 when started, groups 0 to 9 are played. With it at 1, only groups 0 to 6 are played.
- R9: When the last played phase ends, busy_n returns to 1. level_code is 00 whenever busy_n is 1.
- R10: A start pulse while busy_n is 0 has no effect on the waveform or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Table byte write strobe |
| tbl_wr_addr | input | 6 | Table byte address (0 to 59) |
| tbl_wr_data | input | 8 | Table byte value |
| two_color_mode | input | 1 | 1 selects the short group set; sampled at start |
| start | input | 1 | Single-cycle request to begin playback |
| frame_tick | input | 1 | Single-cycle frame advance pulse |
| level_code | output | 2 | Drive-level code of the phase now playing |
| busy_n | output | 1 | Low while a waveform plays |

## Verification
Two functions can meet in one cycle: a start request and a frame tick that advances the current phase while playback runs. The bench pulses start during a playing phase and then keeps ticking. It judges the outcome by comparing level_code and busy_n, frame by frame, against a model built from the table contents. Any restart or lost tick would shift every later level and move the end of busy. The same comparison runs across repeated groups whose zero-length phases are walked between ticks, so that skipping and ticking are seen to stay independent.

// File: rtl/wps_pkg.sv
// Package: shared state encoding and table geometry for the waveform sequencer.
// Assumes a level byte of 8 bits carries one 2-bit code per phase.
package wps_pkg;
    localparam int BYTE_W = 8;

    // Walker states: idle, evaluating a group, evaluating a phase, playing.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GROUP = 2'd1,
        ST_PHASE = 2'd2,
        ST_PLAY  = 2'd3
    } wps_state_e;
endpackage

// File: rtl/wps_lut_store.sv
// Module: byte-wide waveform table with one write port and field reads.
// Does: holds NUM_GROUPS groups of BYTES_PER_GROUP bytes and returns the
// level byte, the frame count of the selected phase and the repeat count
// of the selected group. Assumes group index NUM_GROUPS means "past end";
// reads then return zero.
module wps_lut_store #(
    parameter int NUM_GROUPS      = 10,
    parameter int PHASES          = 4,
    parameter int BYTES_PER_GROUP = PHASES + 2,
    parameter int TOTAL_BYTES     = NUM_GROUPS * BYTES_PER_GROUP,
    parameter int ADDR_W          = $clog2(TOTAL_BYTES),
    parameter int GRP_W           = $clog2(NUM_GROUPS + 1),
    parameter int PH_W            = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [GRP_W-1:0]  grp,
    input  logic [PH_W-1:0]   ph,
    output logic [7:0]        level_byte,
    output logic [7:0]        frame_cnt,
    output logic [7:0]        repeat_cnt
);
    logic [7:0] mem [TOTAL_BYTES];
    int unsigned base;

    // Table storage: cleared by reset, one byte written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL_BYTES; i++) mem[i] <= '0;
        end else if (wr_en && (int'(wr_addr) < TOTAL_BYTES)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Field read: locate the group base and pick the three fields.
    always_comb begin
        base       = int'(grp) * BYTES_PER_GROUP;
        level_byte = '0;
        frame_cnt  = '0;
        repeat_cnt = '0;
        if (int'(grp) < NUM_GROUPS) begin
            level_byte = mem[ADDR_W'(base)];
            frame_cnt  = mem[ADDR_W'(base + 1 + int'(ph))];
            repeat_cnt = mem[ADDR_W'(base + BYTES_PER_GROUP - 1)];
        end
    end

    // Write port must stay inside the table (layout of R3).
    a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < TOTAL_BYTES));
endmodule

// File: rtl/wps_level_pick.sv
// Module: selects the 2-bit level code of one phase from a packed level byte.
// Assumes phase 0 sits in the most significant pair and later phases follow
// toward bit 0; outputs 00 when not playing.
module wps_level_pick #(
    parameter int PHASES  = 4,
    parameter int LEVEL_W = 2,
    parameter int PH_W    = $clog2(PHASES)
) (
    input  logic [PHASES*LEVEL_W-1:0] level_byte,
    input  logic [PH_W-1:0]           ph,
    input  logic                      playing,
    output logic [LEVEL_W-1:0]        level
);
    logic [LEVEL_W-1:0] codes [PHASES];

    // Split the packed byte into per-phase codes, phase 0 on top.
    for (genvar p = 0; p < PHASES; p++) begin : g_split
        assign codes[p] = level_byte[(PHASES-p)*LEVEL_W-1 -: LEVEL_W];
    end

    // Output mux: the current phase's code, or 00 when idle.
    always_comb begin
        level = playing ? codes[ph] : '0;
    end
endmodule

// File: rtl/wps_walker.sv
// Module: group/repeat/phase walker that drives the playback.
// Does: on start, walks groups in order; a group with repeat 0 is passed
// over, a phase with frame count 0 is passed over without consuming a tick,
// and a playing phase counts frame ticks down. Assumes frame ticks are
// spaced wider than the walk across zero-length entries; a tick that lands
// outside the play state is not counted.
module wps_walker
    import wps_pkg::*;
#(
    parameter int NUM_GROUPS   = 10,
    parameter int SHORT_GROUPS = 7,
    parameter int PHASES       = 4,
    parameter int GRP_W        = $clog2(NUM_GROUPS + 1),
    parameter int PH_W         = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             frame_tick,
    input  logic             two_color_mode,
    input  logic [7:0]       frame_cnt,
    input  logic [7:0]       repeat_cnt,
    output logic [GRP_W-1:0] grp,
    output logic [PH_W-1:0]  ph,
    output logic             playing,
    output logic             busy_n
);
    wps_state_e       state;
    logic [7:0]       rep_left;
    logic [7:0]       frames_left;
    logic             short_set;
    logic [GRP_W-1:0] grp_limit;

    wps_state_e       adv_state;
    logic [GRP_W-1:0] adv_grp;
    logic [PH_W-1:0]  adv_ph;
    logic [7:0]       adv_rep;

    // Group limit chosen by the mode latched at start.
    always_comb begin
        grp_limit = short_set ? GRP_W'(SHORT_GROUPS) : GRP_W'(NUM_GROUPS);
    end

    // Next position after the current phase ends (or is passed over).
    always_comb begin
        adv_state = ST_PHASE;
        adv_grp   = grp;
        adv_ph    = ph + PH_W'(1);
        adv_rep   = rep_left;
        if (ph == PH_W'(PHASES - 1)) begin
            adv_ph = '0;
            if (rep_left <= 8'd1) begin
                adv_grp   = grp + GRP_W'(1);
                adv_state = ST_GROUP;
            end else begin
                adv_rep = rep_left - 8'd1;
            end
        end
    end

    // Walker state machine: start, group check, phase check, play.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            grp         <= '0;
            ph          <= '0;
            rep_left    <= '0;
            frames_left <= '0;
            short_set   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_GROUP;
                        grp       <= '0;
                        ph        <= '0;
                        short_set <= two_color_mode;
                    end
                end
                ST_GROUP: begin
                    if (grp >= grp_limit) begin
                        state <= ST_IDLE;
                        grp   <= '0;
                    end else if (repeat_cnt == 8'd0) begin
                        grp <= grp + GRP_W'(1);
                    end else begin
                        rep_left <= repeat_cnt;
                        ph       <= '0;
                        state    <= ST_PHASE;
                    end
                end
                ST_PHASE: begin
                    if (frame_cnt == 8'd0) begin
                        state    <= adv_state;
                        grp      <= adv_grp;
                        ph       <= adv_ph;
                        rep_left <= adv_rep;
                    end else begin
                        frames_left <= frame_cnt;
                        state       <= ST_PLAY;
                    end
                end
                ST_PLAY: begin
                    if (frame_tick) begin
                        if (frames_left == 8'd1) begin
                            state    <= adv_state;
                            grp      <= adv_grp;
                            ph       <= adv_ph;
                            rep_left <= adv_rep;
                        end else begin
                            frames_left <= frames_left - 8'd1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status outputs decoded from the walker state.
    always_comb begin
        playing = (state == ST_PLAY);
        busy_n  = (state == ST_IDLE);
    end

    // R2: an accepted start makes the flag busy on the next edge.
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && start) |=> !busy_n);

    // R5: without a tick, a playing phase keeps its position.
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && !frame_tick) |=> (playing && $stable(grp) && $stable(ph)));

    // R6: a playing phase never has an exhausted frame counter.
    a_r6_no_empty_play: assert property (@(posedge clk) disable iff (!rst_n)
        playing |-> (frames_left != 8'd0));

    // R8: the walk never passes the selected group limit while busy.
    a_r8_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> (grp <= grp_limit));

    // R10: a start while playing leaves the walk untouched.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (playing && start && !frame_tick) |=> (playing && $stable(grp) && $stable(ph)));
endmodule

// File: rtl/wave_phase_seq.sv
// Module: top of the table-driven refresh waveform sequencer.
// Does: ties the table, the walker and the level selector together.
// Assumes a single clock, synchronous active-low reset and 8-bit level
// bytes carrying PHASES codes of LEVEL_W bits.
module wave_phase_seq #(
    parameter int NUM_GROUPS      = 10,
    parameter int SHORT_GROUPS    = 7,
    parameter int PHASES          = 4,
    parameter int LEVEL_W         = 2,
    parameter int BYTES_PER_GROUP = PHASES + 2,
    parameter int TOTAL_BYTES     = NUM_GROUPS * BYTES_PER_GROUP,
    parameter int ADDR_W          = $clog2(TOTAL_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [ADDR_W-1:0] tbl_wr_addr,
    input  logic [7:0]        tbl_wr_data,
    input  logic              two_color_mode,
    input  logic              start,
    input  logic              frame_tick,
    output logic [LEVEL_W-1:0] level_code,
    output logic              busy_n
);
    localparam int GRP_W = $clog2(NUM_GROUPS + 1);
    localparam int PH_W  = $clog2(PHASES);

    logic [GRP_W-1:0] grp;
    logic [PH_W-1:0]  ph;
    logic             playing;
    logic [7:0]       level_byte;
    logic [7:0]       frame_cnt;
    logic [7:0]       repeat_cnt;

    wps_lut_store #(
        .NUM_GROUPS      (NUM_GROUPS),
        .PHASES          (PHASES),
        .BYTES_PER_GROUP (BYTES_PER_GROUP),
        .TOTAL_BYTES     (TOTAL_BYTES),
        .ADDR_W          (ADDR_W),
        .GRP_W           (GRP_W),
        .PH_W            (PH_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr_en),
        .wr_addr    (tbl_wr_addr),
        .wr_data    (tbl_wr_data),
        .grp        (grp),
        .ph         (ph),
        .level_byte (level_byte),
        .frame_cnt  (frame_cnt),
        .repeat_cnt (repeat_cnt)
    );

    wps_walker #(
        .NUM_GROUPS   (NUM_GROUPS),
        .SHORT_GROUPS (SHORT_GROUPS),
        .PHASES       (PHASES),
        .GRP_W        (GRP_W),
        .PH_W         (PH_W)
    ) u_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .frame_tick     (frame_tick),
        .two_color_mode (two_color_mode),
        .frame_cnt      (frame_cnt),
        .repeat_cnt     (repeat_cnt),
        .grp            (grp),
        .ph             (ph),
        .playing        (playing),
        .busy_n         (busy_n)
    );

    wps_level_pick #(
        .PHASES  (PHASES),
        .LEVEL_W (LEVEL_W),
        .PH_W    (PH_W)
    ) u_pick (
        .level_byte (level_byte),
        .ph         (ph),
        .playing    (playing),
        .level      (level_code)
    );

    // R9: with the flag released the output sits at code 00.
    a_r9_idle_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n |-> (level_code == '0));
endmodule

// File: tb/wave_phase_seq_bench.sv
// Directed bench: each task loads a table, plays it and compares every
// frame against a model built from the table mirror.
module wave_phase_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 40;
    localparam int NBYTES     = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_wr_en = 1'b0;
    logic [5:0] tbl_wr_addr = '0;
    logic [7:0] tbl_wr_data = '0;
    logic       two_color_mode = 1'b0;
    logic       start = 1'b0;
    logic       frame_tick = 1'b0;
    logic [1:0] level_code;
    logic       busy_n;

    int checks = 0;
    int fails  = 0;
    logic [7:0] tbl [NBYTES];

    wave_phase_seq u_wave_phase_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .tbl_wr_en      (tbl_wr_en),
        .tbl_wr_addr    (tbl_wr_addr),
        .tbl_wr_data    (tbl_wr_data),
        .two_color_mode (two_color_mode),
        .start          (start),
        .frame_tick     (frame_tick),
        .level_code     (level_code),
        .busy_n         (busy_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int addr, input int val);
        @(negedge clk);
        tbl_wr_en   = 1'b1;
        tbl_wr_addr = 6'(addr);
        tbl_wr_data = 8'(val);
        tbl[addr]   = 8'(val);
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic clear_tbl();
        for (int i = 0; i < NBYTES; i++) wr(i, 0);
    endtask

    task automatic put_group(input int g, input int lv, input int f0, input int f1,
                             input int f2, input int f3, input int rep);
        wr(g*6, lv); wr(g*6+1, f0); wr(g*6+2, f1);
        wr(g*6+3, f2); wr(g*6+4, f3); wr(g*6+5, rep);
    endtask

    // Model: {done, level} after t ticks, from the table mirror.
    function automatic logic [2:0] model(input int t, input bit two);
        int ng = two ? 7 : 10;
        int left = t;
        for (int g = 0; g < ng; g++)
            for (int r = 0; r < int'(tbl[g*6+5]); r++)
                for (int p = 0; p < 4; p++) begin
                    int fc = int'(tbl[g*6+1+p]);
                    if (left < fc) return {1'b0, 2'(tbl[g*6] >> (6 - 2*p))};
                    left -= fc;
                end
        return 3'b100;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_tick(input bit with_start);
        @(negedge clk); frame_tick = 1'b1; start = with_start;
        @(negedge clk); frame_tick = 1'b0; start = 1'b0;
    endtask

    // Play the table and compare each frame; ign_at pulses start with that tick.
    task automatic play(input bit two, input string req, input int ign_at);
        logic [2:0] e;
        two_color_mode = two;
        pulse_start();
        two_color_mode = 1'b0;
        repeat (SETTLE) @(negedge clk);
        for (int t = 0; t < 2000; t++) begin
            e = model(t, two);
            check(req, int'(level_code), int'(e[1:0]));
            check(req, int'(busy_n), int'(e[2]));
            if (e[2]) break;
            pulse_tick(t == ign_at);
            repeat (SETTLE) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1", int'(busy_n), 1);
        check("R1", int'(level_code), 0);
        // R1: table cleared, so a start ends at once.
        for (int i = 0; i < NBYTES; i++) tbl[i] = '0;
        pulse_start();
        repeat (SETTLE) @(negedge clk);
        check("R1", int'(busy_n), 1);
    endtask

    task automatic t_busy_start();
        clear_tbl();
        put_group(0, 8'b01_10_11_00, 1, 1, 1, 1, 1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R2", int'(busy_n), 0);
        repeat (SETTLE) @(negedge clk);
        for (int k = 0; k < 4; k++) begin pulse_tick(1'b0); repeat (SETTLE) @(negedge clk); end
        check("R9", int'(busy_n), 1);
        check("R9", int'(level_code), 0);
    endtask

    task automatic t_basic();
        clear_tbl();
        put_group(0, 8'b01_10_11_00, 2, 1, 3, 1, 1);
        put_group(3, 8'b11_00_10_01, 1, 2, 1, 2, 1);
        play(1'b0, "R3_R4_R5", -1);
    endtask

    task automatic t_skip_repeat();
        clear_tbl();
        put_group(0, 8'b10_11_01_01, 1, 0, 2, 0, 3);
        put_group(1, 8'b11_11_11_11, 4, 4, 4, 4, 0);
        put_group(2, 8'b01_00_10_11, 0, 0, 0, 0, 5);
        put_group(4, 8'b00_01_10_11, 1, 1, 1, 1, 2);
        play(1'b0, "R6_R7", -1);
    endtask

    task automatic t_mode();
        clear_tbl();
        put_group(6, 8'b01_01_01_01, 2, 0, 0, 1, 1);
        put_group(7, 8'b10_10_10_10, 1, 1, 0, 0, 1);
        put_group(9, 8'b11_11_11_11, 0, 0, 0, 2, 1);
        play(1'b1, "R8", -1);
        play(1'b0, "R8", -1);
    endtask

    task automatic t_ignore_start();
        clear_tbl();
        put_group(0, 8'b01_10_11_01, 2, 2, 2, 2, 1);
        play(1'b0, "R10", 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy_start();
        t_basic();
        t_skip_repeat();
        t_mode();
        t_ignore_start();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule